// File: doc/BRIEF.md
# Windowless COP Watchdog Timer

This block is a computer-operating-properly watchdog for a small microcontroller. A free-running counter advances on either a synchronised low-frequency oscillator tick (nominally 1 kHz) or on every bus clock. If software does not clear the counter before it reaches the selected power-of-two limit, the block raises a one-cycle reset request for the chip's reset sequencer. It also sets a sticky cause bit that only a power-on reset clears.

Software configures the watchdog once after each reset. A single configuration word holds the enable bit, the source select and a 3-bit timeout code. The first write after reset is accepted and locks the register until the next reset. A service strobe, driven when software writes the reset status register, clears the counter. While background debug is active the counter holds its value and no reset request can be raised.

Top module: `cop_watchdog`

## Requirements
- R1: After reset the configuration readback `cfg_rd` is 5'b1_0_111: bit 4 is enable=1, bit 3 is source=0 (oscillator), bits 2:0 are timeout code 7. With no software action, the watchdog then times out after about 2^11 oscillator ticks.
- R2: Only the first `cfg_wr` after reset is accepted. Later writes leave `cfg_rd` and the timeout unchanged until `rst_n` is asserted again.
- R3: With source=0, timeout code c (0..6) sets the limit to 2^(5+c) oscillator ticks. Code 7 sets 2^11.
- R4: With source=1, timeout code c (0..6) sets the limit to 2^(13+c) bus cycles. Code 7 sets 2^19. `reset_req` goes high exactly limit clock edges after the edge that took the clearing strobe.
- R5: A `svc` strobe clears the counter and takes priority over a same-cycle overflow. Servicing at intervals shorter than the limit prevents any reset request.
- R6: While `dbg_active` is high the counter holds and `reset_req` stays low. Each cycle spent in debug delays the timeout by one cycle.
- R7: With the enable bit cleared, `reset_req` never rises.
- R8: `reset_req` is high for exactly one bus clock per overflow.
- R9: `cause_flag` is set on an overflow. It stays set through `rst_n` and is cleared only by `por_n`.
- R10: Accepting the one-time configuration write clears the counter, so the new limit is counted from that edge.
- R11: `lfo_tick` is synchronised into the bus clock domain. Each rising edge advances the counter once when the oscillator source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous system reset, active low; restores and unlocks configuration |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the cause flag |
| lfo_tick | input | 1 | Asynchronous low-frequency oscillator clock |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | {enable, source, timeout[2:0]} |
| svc | input | 1 | Service strobe; clears the counter |
| dbg_active | input | 1 | Background debug active; freezes the counter |
| cfg_rd | output | 5 | Configuration readback, same layout as cfg_wdata |
| reset_req | output | 1 | One-cycle reset request on overflow |
| cause_flag | output | 1 | Sticky "watchdog caused reset" status |

## Verification
The bus-clock source is timed to the exact cycle for codes 0 and 1, which separates a correct limit from an off-by-one or a swapped code. The oscillator source is timed inside a window for codes 0, 6 and 7. This separates neighbouring powers of two and shows that code 7 repeats the limit of code 6. Freezes, disabled runs and periodic servicing are checked over spans longer than the limit: a counter that leaks through debug or ignores enable fires inside the span. A late configuration write and a write after a long idle show whether the lock holds and whether the accepted write restarts the count.

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
  parameter int CNT_W     = 19,
  parameter int SYNC_N    = 2,
  parameter int TMO_W     = 3,
  parameter int LFO_BASE  = 5,
  parameter int BUS_BASE  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              lfo_tick,
  input  logic              cfg_wr,
  input  logic [TMO_W+1:0]  cfg_wdata,
  input  logic              svc,
  input  logic              dbg_active,
  output logic [TMO_W+1:0]  cfg_rd,
  output logic              reset_req,
  output logic              cause_flag
);
  localparam int CODE_MAX = (1 << TMO_W) - 1;

  logic             en_q, src_q, locked_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic [CNT_W:0]   lim;
  logic [SYNC_N:0]  lfo_sh;
  logic             tick_en, cfg_take, inc, hit;
  int unsigned      shamt, code_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfo_sh <= '0;
    else        lfo_sh <= {lfo_sh[SYNC_N-1:0], lfo_tick};

  assign tick_en = lfo_sh[SYNC_N-1] & ~lfo_sh[SYNC_N];

  assign cfg_take = cfg_wr & ~locked_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q     <= 1'b1;
      src_q    <= 1'b0;
      tmo_q    <= TMO_W'(CODE_MAX);
      locked_q <= 1'b0;
    end else if (cfg_take) begin
      en_q     <= cfg_wdata[TMO_W+1];
      src_q    <= cfg_wdata[TMO_W];
      tmo_q    <= cfg_wdata[TMO_W-1:0];
      locked_q <= 1'b1;
    end

  assign cfg_rd = {en_q, src_q, tmo_q};

  always_comb begin
    code_eff = (tmo_q == TMO_W'(CODE_MAX)) ? CODE_MAX - 1 : int'(tmo_q);
    shamt    = (src_q ? BUS_BASE : LFO_BASE) + code_eff;
    lim      = (CNT_W+1)'(1) << shamt;
  end

  assign lim_m1 = CNT_W'(lim - 1'b1);

  assign inc = en_q & ~dbg_active & (src_q | tick_en);
  assign hit = inc & (cnt_q == lim_m1) & ~svc & ~cfg_take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt_q <= '0;
    else if (svc || cfg_take)    cnt_q <= '0;
    else if (hit)                cnt_q <= '0;
    else if (inc)                cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= hit;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)   cause_flag <= 1'b0;
    else if (hit) cause_flag <= 1'b1;

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_q) |-> $stable(cfg_rd));

  // R5
  svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !reset_req);

  // R6
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> !$past(dbg_active));

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(en_q));

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reset_req |-> cause_flag);
endmodule

// File: tb/test_cop_watchdog.sv
module test_cop_watchdog;
  logic       clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, lfo_tick = 1'b0;
  logic       cfg_wr = 1'b0, svc = 1'b0, dbg_active = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rd;
  logic       reset_req, cause_flag;
  int         errors = 0, checks = 0, cyc = 0;

  cop_watchdog i_cop_watchdog (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .lfo_tick(lfo_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .svc(svc), .dbg_active(dbg_active),
    .cfg_rd(cfg_rd), .reset_req(reset_req), .cause_flag(cause_flag));

  always #5 clk = ~clk;
  always #20 lfo_tick = ~lfo_tick;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; dbg_active = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [4:0] d);
    @(negedge clk); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic svc_pulse();
    @(negedge clk); svc = 1'b1;
    @(negedge clk); svc = 1'b0;
  endtask

  task automatic wait_req(input int maxc, output int n);
    for (int k = 1; k <= maxc; k++) begin
      @(posedge clk); @(negedge clk);
      if (reset_req) begin n = k; return; end
    end
    n = -1;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(cfg_rd == 5'b10111, "R1 reset cfg", cfg_rd, 5'b10111);
    chk(reset_req == 1'b0, "R8 reset_req idle", reset_req, 0);
    chk(cause_flag == 1'b0, "R9 flag after por", cause_flag, 0);
  endtask

  task automatic t_default_timeout();
    int n;
    do_reset();
    wait_req(12000, n);
    chk(n >= 8184 && n <= 8204, "R1 R3 R11 default lfo code7", n, 8192);
    @(negedge clk);
    chk(reset_req == 1'b0, "R8 pulse width", reset_req, 0);
    chk(cause_flag == 1'b1, "R9 flag set", cause_flag, 1);
  endtask

  task automatic t_bus_code0_and_lock();
    int n;
    do_reset();
    wr_cfg(5'b11000);
    chk(cfg_rd == 5'b11000, "R2 first write", cfg_rd, 5'b11000);
    wait_req(9000, n);
    chk(n == 8192, "R4 R10 bus code0", n, 8192);
    wr_cfg(5'b10011);
    chk(cfg_rd == 5'b11000, "R2 second write ignored", cfg_rd, 5'b11000);
    svc_pulse();
    wait_req(9000, n);
    chk(n == 8192, "R2 limit unchanged", n, 8192);
  endtask

  task automatic t_bus_code1();
    int n;
    do_reset();
    wr_cfg(5'b11001);
    wait_req(17000, n);
    chk(n == 16384, "R4 bus code1", n, 16384);
  endtask

  task automatic t_lfo_codes();
    int n;
    do_reset();
    wr_cfg(5'b10000);
    wait_req(400, n);
    chk(n >= 120 && n <= 140, "R3 R11 lfo code0", n, 128);
    do_reset();
    wr_cfg(5'b10110);
    wait_req(12000, n);
    chk(n >= 8184 && n <= 8204, "R3 lfo code6", n, 8192);
  endtask

  task automatic t_debug();
    int n = -1;
    do_reset();
    wr_cfg(5'b11000);
    for (int k = 1; k <= 12000; k++) begin
      @(posedge clk); @(negedge clk);
      if (reset_req) begin n = k; break; end
      if (k == 1000) dbg_active = 1'b1;
      if (k == 1500) dbg_active = 1'b0;
    end
    chk(n == 8692, "R6 freeze delays timeout", n, 8692);
    @(negedge clk); dbg_active = 1'b1;
    wait_req(10000, n);
    chk(n == -1, "R6 no reset in debug", n, -1);
    dbg_active = 1'b0;
  endtask

  task automatic t_disabled();
    int n;
    do_reset();
    wr_cfg(5'b01000);
    wait_req(20000, n);
    chk(n == -1, "R7 disabled", n, -1);
  endtask

  task automatic t_service();
    int n;
    do_reset();
    wr_cfg(5'b11000);
    for (int k = 0; k < 4; k++) begin
      wait_req(5000, n);
      chk(n == -1, "R5 serviced no reset", n, -1);
      svc_pulse();
    end
    wait_req(9000, n);
    chk(n == 8192, "R5 count from service", n, 8192);
  endtask

  task automatic t_late_cfg();
    int n;
    do_reset();
    wait_req(6000, n);
    chk(n == -1, "R10 idle before write", n, -1);
    wr_cfg(5'b11000);
    wait_req(9000, n);
    chk(n == 8192, "R10 write restarts count", n, 8192);
  endtask

  task automatic t_sticky();
    do_reset();
    @(negedge clk);
    chk(cause_flag == 1'b1, "R9 flag survives rst_n", cause_flag, 1);
    por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk(cause_flag == 1'b0, "R9 por clears flag", cause_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    t_reset_state();
    t_default_timeout();
    t_bus_code0_and_lock();
    t_bus_code1();
    t_lfo_codes();
    t_debug();
    t_disabled();
    t_service();
    t_late_cfg();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule